// File: doc/BRIEF.md
# Clock-Terminated Event Interval Gate

This block produces the timing window for one detector cell. A rising edge on the event input opens the gate output at once, with no clock involved. The local clock then samples that asynchronous flag, and the clock edge after the sampling edge force-clears it. This closes the window. The window therefore always lasts more than one clock period and at most two. That spacing gives the analog measuring circuit time to recover even when the event lands right next to a clock edge.

Once the window closes, the cell asks the control side for a conversion. The request is held until the control side answers. The cell then drives a baseline-reset pulse and rearms for the next event. While the cell is busy, from the opening of the window until the baseline pulse ends, further event edges have no effect.

The request and done pair is a valid/ready style handshake. The request is the valid side. It stays high and does not change until done is sampled high on a rising clock edge. Holding done low is back-pressure: the cell simply waits, for as many cycles as needed. Done sampled while no request is pending is ignored.

Top module: `interval_gate`

## Requirements
- R1: An active-low asynchronous reset drives gate_o, conv_req_o and base_rst_o low at once, with no clock edge needed, and leaves the cell armed.
- R2: While armed, a rising edge on evt_i raises gate_o immediately, before any clock edge.
- R3: gate_o falls just after the second rising clock edge that follows the event edge. The window therefore lasts more than one and at most two clock periods: with the event at offset d after a clock edge and period T, the width is 2T - d.
- R4: conv_req_o rises on the same clock edge that closes the window. It stays high until conv_done_i is sampled high on a rising clock edge.
- R5: On the edge where conv_done_i is sampled high with conv_req_o high, conv_req_o drops and base_rst_o rises. base_rst_o stays high for exactly BASE_CYCLES clock cycles (default 1). conv_req_o and base_rst_o are never high together.
- R6: Event edges that arrive from the opening of the window until the baseline pulse ends do not raise gate_o and do not start another request.
- R7: After the baseline pulse ends, the cell is armed again, and the next event edge opens a new window under R2 and R3.
- R8: conv_done_i sampled high while no request is pending has no effect: base_rst_o and conv_req_o stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local precision clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 1 | Discriminated event pulse, asynchronous to clk |
| conv_done_i | input | 1 | Conversion finished, returned by the control side |
| gate_o | output | 1 | Measured-interval window |
| conv_req_o | output | 1 | Conversion request, held until done |
| base_rst_o | output | 1 | Baseline reset pulse for the analog cell |

## Verification
The bench builds the block with its default BASE_CYCLES of 1, so the baseline pulse can be checked as exactly one clock wide. At 8 ns per clock, events are placed at offsets from 0.5 ns to 7.5 ns after an edge. This covers windows from just over one period up to nearly two, and the expected width is computed as 16 ns minus the offset. The bench also holds done off for several cycles, which exercises back-pressure, fires stray events during the request and baseline phases, and resets the cell in the middle of a request.

// File: rtl/ivg_pkg.sv
`timescale 1ns/1ps
package ivg_pkg;
  typedef enum logic [1:0] {
    ST_ARMED    = 2'd0,
    ST_CONVERT  = 2'd1,
    ST_BASELINE = 2'd2
  } ivg_state_t;
endpackage

// File: rtl/ivg_catch.sv
`timescale 1ns/1ps
// Asynchronous event flag plus clock-domain sampler.
module ivg_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic busy_i,
  output logic gate_o,
  output logic samp_o
);
  logic flag_q;
  logic samp_q;

  // Flag: set by the event edge itself; held clear while the cell is busy.
  always_ff @(posedge evt_i or posedge busy_i or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (busy_i) flag_q <= 1'b0;
    else             flag_q <= 1'b1;
  end

  // Sampler: the flag as seen by the local clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= 1'b0;
    else        samp_q <= flag_q;
  end

  assign gate_o = flag_q;
  assign samp_o = samp_q;

  // R6: once busy has been seen on two edges, the window is shut
  a_r6_gate_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i)) |-> !gate_o);
  // R3: the window never survives a third edge after sampling
  a_r3_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_q && $past(samp_q)) |-> !gate_o);
endmodule

// File: rtl/ivg_seq.sv
`timescale 1ns/1ps
// Busy sequencer: request / done handshake and baseline pulse.
module ivg_seq import ivg_pkg::*; #(
  parameter int unsigned BASE_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_i,
  input  logic done_i,
  output logic busy_o,
  output logic req_o,
  output logic base_o
);
  localparam int unsigned CW = (BASE_CYCLES > 1) ? $clog2(BASE_CYCLES) : 1;
  localparam logic [CW-1:0] BASE_LAST = CW'(BASE_CYCLES - 1);

  ivg_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic busy_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_ARMED:    if (samp_i) st_d = ST_CONVERT;
      ST_CONVERT:  if (done_i) begin st_d = ST_BASELINE; cnt_d = '0; end
      ST_BASELINE: begin
        if (cnt_q == BASE_LAST) st_d = ST_ARMED;
        else                    cnt_d = cnt_q + 1'b1;
      end
      default:     st_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ARMED;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      busy_q <= (st_d != ST_ARMED);
    end
  end

  assign busy_o = busy_q;
  assign req_o  = (st_q == ST_CONVERT);
  assign base_o = (st_q == ST_BASELINE);

  // R4: request holds until done is seen
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !done_i) |=> req_o);
  // R4: request only starts after the sampler saw the window
  a_r4_req_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(samp_i));
  // R5: done accepted moves straight to baseline
  a_r5_base_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && done_i) |=> (base_o && !req_o));
  // R5: the two outputs are exclusive
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_o && base_o));
  // R8: done alone never starts a baseline pulse
  a_r8_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && !base_o) |=> !base_o);
endmodule

// File: rtl/interval_gate.sv
`timescale 1ns/1ps
module interval_gate #(
  parameter int unsigned BASE_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic conv_done_i,
  output logic gate_o,
  output logic conv_req_o,
  output logic base_rst_o
);
  logic busy;
  logic samp;

  ivg_catch u_catch (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .busy_i (busy),
    .gate_o (gate_o),
    .samp_o (samp)
  );

  ivg_seq #(.BASE_CYCLES(BASE_CYCLES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .samp_i (samp),
    .done_i (conv_done_i),
    .busy_o (busy),
    .req_o  (conv_req_o),
    .base_o (base_rst_o)
  );
endmodule

// File: tb/test_interval_gate.sv
`timescale 1ns/1ps
module test_interval_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt = 1'b0;
  logic done = 1'b0;
  logic gate, req, base;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  real exp_q[$];
  int measured = 0;
  int pushed = 0;

  always #4 clk = ~clk;

  interval_gate #(.BASE_CYCLES(1)) i_interval_gate (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .conv_done_i(done),
    .gate_o(gate), .conv_req_o(req), .base_rst_o(base)
  );

  task automatic chk(input string req_tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req_tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Short event pulse at time now; checks gate state shortly after.
  task automatic pulse_evt(input string tag, input logic exp_gate);
    evt = 1'b1;
    #0.2;
    chk(tag, gate, exp_gate);
    #0.1;
    evt = 1'b0;
  endtask

  // Driver: event at offset off after a rising edge; expect width 16-off.
  task automatic fire(input real off);
    @(posedge clk);
    #(off);
    exp_q.push_back(16.0 - off);
    pushed++;
    pulse_evt("R2/R7 gate opens at event", 1'b1);
    @(posedge clk); #1;
    chk("R3 gate open after first edge", gate, 1'b1);
    chk("R4 no request before close", req, 1'b0);
    @(posedge clk); #1;
    chk("R3 gate closed at second edge", gate, 1'b0);
    chk("R4 request at close", req, 1'b1);
  endtask

  task automatic finish_cycle(input int wait_cycles);
    for (int i = 0; i < wait_cycles; i++) begin
      @(posedge clk); #1;
      chk("R4 request held without done", req, 1'b1);
    end
    #1;
    pulse_evt("R6 event ignored during request", 1'b0);
    done = 1'b1;
    @(posedge clk); #1;
    done = 1'b0;
    chk("R5 baseline after done", base, 1'b1);
    chk("R5 request dropped", req, 1'b0);
    pulse_evt("R6 event ignored during baseline", 1'b0);
    @(posedge clk); #1;
    chk("R5 baseline one cycle", base, 1'b0);
    chk("R6 no new request", req, 1'b0);
  endtask

  // Monitor: measure every window and compare against the queue.
  initial begin
    forever begin
      realtime t0, w;
      real e;
      @(posedge gate);
      t0 = $realtime;
      @(negedge gate);
      w = $realtime - t0;
      measured++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected window actual=%0f expected=none", w);
      end else begin
        e = exp_q.pop_front();
        if (w < e - 0.01 || w > e + 0.01) begin
          errors++;
          $display("FAIL R3 window width actual=%0f expected=%0f", w, e);
        end
      end
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    #3;
    chk("R1 gate low in reset", gate, 1'b0);
    chk("R1 request low in reset", req, 1'b0);
    chk("R1 baseline low in reset", base, 1'b0);
    pulse_evt("R1 event ignored in reset", 1'b0);
    #10 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R8: stray done while armed
    #1 done = 1'b1;
    @(posedge clk); #1;
    done = 1'b0;
    chk("R8 done ignored baseline", base, 1'b0);
    chk("R8 done ignored request", req, 1'b0);

    fire(0.5);  finish_cycle(0);
    fire(2.0);  finish_cycle(3);
    fire(4.0);  finish_cycle(1);
    fire(6.5);  finish_cycle(5);
    fire(7.5);  finish_cycle(2);

    // R1: reset in the middle of a request
    fire(3.0);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async reset clears request", req, 1'b0);
    chk("R1 async reset keeps baseline low", base, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    // R7: rearmed after reset
    fire(1.0);  finish_cycle(1);

    repeat (3) @(posedge clk);
    checks++;
    if (exp_q.size() != 0 || measured != pushed) begin
      errors++;
      $display("FAIL R3 scoreboard actual=%0d expected=%0d", measured, pushed);
    end
    finish_run();
  end
endmodule